// File: doc/BRIEF.md
# Read Response Queue with Double-Bit ECC Status

This block sits on the read-return side of a memory controller. Each completed read arrives with a data word, a requester tag, a flag from the upstream ECC decoder that marks an uncorrectable double-bit error, and the address that was read. The completion is written into a circular queue of 32 slots. Slots are filled and emptied in strict rotation. Responses leave in arrival order on a valid/ready response channel.

Every slot keeps its own data, tag and error flag together. The status code sent with a response is therefore taken from that slot's own flag and from nothing else. The error flag of one slot can never reach the next response, and a clean neighbour can never hide an error.

Alongside the queue, a small register path reports the same errors to software. An accepted completion that carries the error flag sets a raw status bit, whether or not the interrupt is enabled. The address of the first such error is captured in a log register. An enable bit, set and cleared through separate write-one registers, gates the raw bit onto a masked status bit and onto an interrupt line.

Top module: `rdresp_ecc_queue`

## Requirements
- R1: The queue holds 32 entries. `in_ready` is low exactly when all 32 are occupied, and a completion offered while full is neither stored nor flagged.
- R2: Responses leave in the order their completions were accepted. Each carries the data and tag it was pushed with, including across pointer wraparound.
- R3: `rsp_status` is 2'b10 when the response's own stored error flag is set and 2'b00 otherwise. This holds regardless of the flags in adjacent slots.
- R4: `rsp_valid` is low when the queue is empty. While `rsp_valid` is high and `rsp_ready` is low, data, tag and status hold steady.
- R5: Bit 4 of `irq_raw` is set in the cycle after an error-flagged completion is accepted, independent of the enable. All other bits of `irq_raw`, `irq_masked` and `irq_enable` read 0.
- R6: A register write with `csr_sel`=0 and `csr_wdata[4]`=1 clears raw bit 4. A write with bit 4 at zero leaves it unchanged. If an error is accepted in the same cycle as the clear, the bit stays set.
- R7: A write with `csr_sel`=1 sets enable bit 4 when `csr_wdata[4]`=1, and a write with `csr_sel`=2 clears it when `csr_wdata[4]`=1. Other data bits have no effect on either register.
- R8: `irq_masked[4]` and `irq_out` are high exactly when both raw bit 4 and enable bit 4 are set.
- R9: `err_addr_log` captures the 32-bit address of an accepted error completion when raw bit 4 is clear, or is being cleared in that cycle. Later errors do not overwrite it while the bit stays set.
- R10: After reset the queue is empty, `in_ready` is high, and all status, enable, log and interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Read completion offered |
| in_ready | output | 1 | Queue can accept a completion |
| in_data | input | 32 | Completion data word |
| in_tag | input | 6 | Requester tag |
| in_derr | input | 1 | Double-bit ECC error flag from decoder |
| in_addr | input | 32 | Address of the completed read |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response consumer accepts |
| rsp_data | output | 32 | Response data word |
| rsp_tag | output | 6 | Response requester tag |
| rsp_status | output | 2 | 2'b00 okay, 2'b10 slave error |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | 0 raw status clear, 1 enable set, 2 enable clear |
| csr_wdata | input | 32 | Register write data |
| irq_raw | output | 32 | Raw interrupt status, bit 4 live |
| irq_enable | output | 32 | Interrupt enable, bit 4 live |
| irq_masked | output | 32 | Raw AND enable |
| irq_out | output | 1 | Interrupt line |
| err_addr_log | output | 32 | Address of the first logged error |

## Verification
The queue is first driven with an all-clean burst. This shows that OKAY is the default and that no interrupt appears. It then fills all 32 slots with errors in isolated and back-to-back positions, both after a clean slot and before one, starting from an offset pointer. This separates a correct per-slot flag from a flag that bleeds into the next slot or is masked by it. A long push-then-pop run with a periodic error pattern crosses pointer wraparound. The register tests apply writes with the live bit both set and clear, enable the interrupt before and after an error, and issue a raw clear in the same cycle as a new error. These cases tell priority and first-capture logging apart from simple last-write behaviour.

// File: rtl/rdq_pkg.sv
// Package: shared constants for the read response queue.
// Assumes: one live interrupt bit at position ERR_BIT of 32-bit registers.
package rdq_pkg;
    localparam int REG_W   = 32;
    localparam int ERR_BIT = 4;

    typedef enum logic [1:0] {
        RSP_OKAY   = 2'b00,
        RSP_SLVERR = 2'b10
    } rsp_code_e;

    localparam logic [1:0] SEL_RAW_W1C = 2'd0;
    localparam logic [1:0] SEL_EN_W1S  = 2'd1;
    localparam logic [1:0] SEL_EN_W1C  = 2'd2;
endpackage

// File: rtl/rdq_ring.sv
// Module: rdq_ring
// Circular buffer of DEPTH slots, each holding a packed W-bit entry.
// The write pointer and the read pointer advance in rotation. Output is
// read combinationally from the head slot.
// Assumes: DEPTH is a power of two; push is only asserted when not full
// and pop only when not empty (the caller gates them).
module rdq_ring #(
    parameter int W     = 39,
    parameter int DEPTH = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_entry,
    input  logic         pop,
    output logic [W-1:0] head_entry,
    output logic         full,
    output logic         empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic [W-1:0]     slot_q [DEPTH];

    // Per-slot storage: each slot loads only when it is the write target.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (push && (wr_ptr == PTR_W'(g)))
                slot_q[g] <= push_entry;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Flags and head view.
    always_comb begin
        full       = (count == CNT_W'(DEPTH));
        empty      = (count == '0);
        head_entry = slot_q[rd_ptr];
    end
endmodule

// File: rtl/rdq_irq_ctl.sv
// Module: rdq_irq_ctl
// Raw status, enable and masked status for the double-bit error interrupt,
// plus the failing address log.
// Raw bit: set by an error event, cleared by write-one; set wins.
// Enable bit: write-one-to-set and write-one-to-clear registers; set wins.
// Log: loads on an error when raw is clear or being cleared this cycle.
// Assumes: err_evt is a single-cycle strobe per accepted error completion.
module rdq_irq_ctl
    import rdq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_evt,
    input  logic [AW-1:0]    err_addr,
    input  logic             csr_we,
    input  logic [1:0]       csr_sel,
    input  logic [REG_W-1:0] csr_wdata,
    output logic [REG_W-1:0] irq_raw,
    output logic [REG_W-1:0] irq_enable,
    output logic [REG_W-1:0] irq_masked,
    output logic             irq_out,
    output logic [AW-1:0]    err_addr_log
);
    logic raw_q, en_q;
    logic raw_clr, en_set, en_clr, log_load;

    // Decode register write strobes for the live bit.
    always_comb begin
        raw_clr  = csr_we && (csr_sel == SEL_RAW_W1C) && csr_wdata[ERR_BIT];
        en_set   = csr_we && (csr_sel == SEL_EN_W1S)  && csr_wdata[ERR_BIT];
        en_clr   = csr_we && (csr_sel == SEL_EN_W1C)  && csr_wdata[ERR_BIT];
        log_load = err_evt && (!raw_q || raw_clr);
    end

    // Raw status bit: error set takes priority over software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       raw_q <= 1'b0;
        else if (err_evt) raw_q <= 1'b1;
        else if (raw_clr) raw_q <= 1'b0;
    end

    // Enable bit: set takes priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= 1'b0;
        else if (en_set) en_q <= 1'b1;
        else if (en_clr) en_q <= 1'b0;
    end

    // Address log: first error since the raw bit was last clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        err_addr_log <= '0;
        else if (log_load) err_addr_log <= err_addr;
    end

    // Expand live bits onto full-width register views.
    always_comb begin
        irq_raw             = '0;
        irq_enable          = '0;
        irq_masked          = '0;
        irq_raw[ERR_BIT]    = raw_q;
        irq_enable[ERR_BIT] = en_q;
        irq_masked[ERR_BIT] = raw_q & en_q;
        irq_out             = raw_q & en_q;
    end
endmodule

// File: rtl/rdresp_ecc_queue.sv
// Module: rdresp_ecc_queue (top)
// Read completions enter a circular queue with their own data, tag and
// double-bit error flag. They leave in order with a status code derived
// from their own flag. Accepted error completions also drive the
// interrupt/log block.
// Assumes: DEPTH is a power of two; the decoder's flag is valid with in_valid.
module rdresp_ecc_queue
    import rdq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 6,
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              in_derr,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [1:0]        rsp_status,
    input  logic              csr_we,
    input  logic [1:0]        csr_sel,
    input  logic [REG_W-1:0]  csr_wdata,
    output logic [REG_W-1:0]  irq_raw,
    output logic [REG_W-1:0]  irq_enable,
    output logic [REG_W-1:0]  irq_masked,
    output logic              irq_out,
    output logic [ADDR_W-1:0] err_addr_log
);
    localparam int ENT_W = DATA_W + TAG_W + 1;

    logic             q_full, q_empty, do_push, do_pop;
    logic [ENT_W-1:0] push_ent, head_ent;
    logic             head_derr;

    // Handshake qualification and entry packing.
    always_comb begin
        in_ready  = !q_full;
        rsp_valid = !q_empty;
        do_push   = in_valid && in_ready;
        do_pop    = rsp_valid && rsp_ready;
        push_ent  = {in_derr, in_tag, in_data};
    end

    rdq_ring #(
        .W     (ENT_W),
        .DEPTH (DEPTH)
    ) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (do_push),
        .push_entry (push_ent),
        .pop        (do_pop),
        .head_entry (head_ent),
        .full       (q_full),
        .empty      (q_empty)
    );

    // Unpack the head slot; status comes from that slot's own flag.
    always_comb begin
        rsp_data   = head_ent[DATA_W-1:0];
        rsp_tag    = head_ent[DATA_W +: TAG_W];
        head_derr  = head_ent[ENT_W-1];
        rsp_status = head_derr ? RSP_SLVERR : RSP_OKAY;
    end

    rdq_irq_ctl #(
        .AW (ADDR_W)
    ) u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .err_evt      (do_push && in_derr),
        .err_addr     (in_addr),
        .csr_we       (csr_we),
        .csr_sel      (csr_sel),
        .csr_wdata    (csr_wdata),
        .irq_raw      (irq_raw),
        .irq_enable   (irq_enable),
        .irq_masked   (irq_masked),
        .irq_out      (irq_out),
        .err_addr_log (err_addr_log)
    );
endmodule

// File: rtl/rdresp_ecc_queue_chk.sv
// Module: rdresp_ecc_queue_chk
// Port-level properties of the read response queue, bound to the top.
module rdresp_ecc_queue_chk
    import rdq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 6,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_derr,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [DATA_W-1:0] rsp_data,
    input logic [TAG_W-1:0]  rsp_tag,
    input logic [1:0]        rsp_status,
    input logic              csr_we,
    input logic [1:0]        csr_sel,
    input logic [REG_W-1:0]  csr_wdata,
    input logic [REG_W-1:0]  irq_raw,
    input logic [REG_W-1:0]  irq_enable,
    input logic [REG_W-1:0]  irq_masked,
    input logic              irq_out,
    input logic [ADDR_W-1:0] err_addr_log
);
    localparam logic [REG_W-1:0] DEAD_MASK = ~(REG_W'(1) << ERR_BIT);

    // R1: a full queue is never empty.
    p_full_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> rsp_valid);

    // R3: only the two defined codes appear.
    p_status_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status == RSP_OKAY || rsp_status == RSP_SLVERR));

    // R4: a stalled response holds.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)
            && $stable(rsp_tag) && $stable(rsp_status));

    // R5: an accepted error sets the raw bit.
    p_raw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_derr |=> irq_raw[ERR_BIT]);

    // R5: unused bits stay zero.
    p_dead_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones((irq_raw | irq_enable | irq_masked) & DEAD_MASK) == 0);

    // R8: the interrupt needs both raw and enable.
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> irq_raw[ERR_BIT] && irq_enable[ERR_BIT] && irq_masked[ERR_BIT]);

    // R9: the log holds while raw stays set and no clear is written.
    p_log_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_raw[ERR_BIT] && !(csr_we && csr_sel == SEL_RAW_W1C && csr_wdata[ERR_BIT])
            |=> $stable(err_addr_log));
endmodule

bind rdresp_ecc_queue rdresp_ecc_queue_chk #(
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/tb_rdresp_ecc_queue.sv
// Directed bench for rdresp_ecc_queue: one task per scenario.
module tb_rdresp_ecc_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_derr = 1'b0, rsp_ready = 1'b0, csr_we = 1'b0;
    logic [31:0] in_data = '0, in_addr = '0, csr_wdata = '0;
    logic [5:0]  in_tag = '0;
    logic [1:0]  csr_sel = '0;
    logic        in_ready, rsp_valid, irq_out;
    logic [31:0] rsp_data, irq_raw, irq_enable, irq_masked, err_addr_log;
    logic [5:0]  rsp_tag;
    logic [1:0]  rsp_status;

    int n_chk = 0, n_fail = 0;
    logic [31:0] m_data[$];
    logic [5:0]  m_tag[$];
    logic        m_err[$];

    always #2 clk = ~clk;

    rdresp_ecc_queue dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] d, input logic [5:0] t, input logic e,
                        input logic [31:0] a);
        bit acc;
        @(negedge clk);
        in_data = d; in_tag = t; in_derr = e; in_addr = a; in_valid = 1'b1;
        acc = in_ready;
        @(negedge clk);
        in_valid = 1'b0; in_derr = 1'b0;
        if (acc) begin m_data.push_back(d); m_tag.push_back(t); m_err.push_back(e); end
    endtask

    task automatic pop_check(input string req);
        logic [31:0] ed; logic [5:0] et; logic ee;
        @(negedge clk);
        ed = m_data.pop_front(); et = m_tag.pop_front(); ee = m_err.pop_front();
        chk(rsp_valid == 1'b1, {req, " R4 valid"}, rsp_valid, 1);
        chk(rsp_data == ed, {req, " R2 data"}, rsp_data, ed);
        chk(rsp_tag == et, {req, " R2 tag"}, rsp_tag, et);
        chk(rsp_status == (ee ? 2'b10 : 2'b00), {req, " R3 status"}, rsp_status,
            ee ? 2'b10 : 2'b00);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic csr_wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
        chk(rsp_valid == 1'b0, "R10 rsp_valid", rsp_valid, 0);
        chk(irq_raw == 0 && irq_enable == 0 && irq_masked == 0 && irq_out == 0,
            "R10 irq regs", irq_raw | irq_enable | irq_masked, 0);
        chk(err_addr_log == 0, "R10 log", err_addr_log, 0);
    endtask

    task automatic t_clean_burst;
        for (int i = 0; i < 5; i++) push(32'hC000_0000 + i, 6'(i + 3), 1'b0, 32'h100 + i);
        for (int i = 0; i < 5; i++) pop_check("clean");
        chk(irq_raw == 0 && irq_out == 0, "R5 no error no raw", irq_raw, 0);
    endtask

    task automatic t_fill_adjacent;
        for (int i = 0; i < 32; i++) begin
            bit e;
            e = (i == 15 || i == 16 || i == 20 || i == 23);
            push(32'hD000_0000 + i, 6'(i), e, 32'hA000_0000 + i);
        end
        @(negedge clk);
        chk(in_ready == 1'b0, "R1 full", in_ready, 0);
        push(32'hBAD0_BAD0, 6'h3F, 1'b1, 32'hFFFF_FFFF);   // refused while full
        chk(m_data.size() == 32, "R1 refused push", m_data.size(), 32);
        chk(err_addr_log == 32'hA000_000F, "R9 first error logged", err_addr_log,
            32'hA000_000F);
        // R4: stalled head holds.
        repeat (3) @(negedge clk);
        chk(rsp_data == 32'hD000_0000, "R4 stall hold", rsp_data, 32'hD000_0000);
        for (int i = 0; i < 32; i++) pop_check("fill");
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R4 empty", rsp_valid, 0);
        chk(in_ready == 1'b1, "R1 ready after drain", in_ready, 1);
    endtask

    task automatic t_wrap;
        for (int i = 0; i < 40; i++) begin
            push(32'hE000_0000 + i, 6'(i ^ 6'h2A), (i % 3) == 0, 32'hB000_0000 + i);
            pop_check("wrap");
        end
        chk(irq_raw[4] == 1'b1, "R5 raw set without enable", irq_raw[4], 1);
        chk(irq_out == 1'b0, "R8 no irq when disabled", irq_out, 0);
        chk(err_addr_log == 32'hA000_000F, "R9 log not overwritten", err_addr_log,
            32'hA000_000F);
    endtask

    task automatic t_irq;
        csr_wr(2'd0, 32'hFFFF_FFEF);
        chk(irq_raw[4] == 1'b1, "R6 clear with bit4 zero ignored", irq_raw[4], 1);
        csr_wr(2'd0, 32'h10);
        chk(irq_raw == 0, "R6 raw cleared", irq_raw, 0);
        csr_wr(2'd1, 32'hFFFF_FFEF);
        chk(irq_enable == 0, "R7 set with bit4 zero ignored", irq_enable, 0);
        csr_wr(2'd1, 32'h10);
        chk(irq_enable == 32'h10, "R7 enable set", irq_enable, 32'h10);
        chk(irq_out == 1'b0, "R8 no irq without raw", irq_out, 0);
        push(32'h1111_1111, 6'h11, 1'b1, 32'h0000_5550);
        chk(irq_out == 1'b1 && irq_masked == 32'h10, "R8 irq raised", irq_masked, 32'h10);
        chk(err_addr_log == 32'h0000_5550, "R9 new first error", err_addr_log, 32'h5550);
        push(32'h2222_2222, 6'h22, 1'b1, 32'h0000_6660);
        chk(err_addr_log == 32'h0000_5550, "R9 second error kept out", err_addr_log, 32'h5550);
        csr_wr(2'd2, 32'hFFFF_FFEF);
        chk(irq_enable == 32'h10, "R7 clear with bit4 zero ignored", irq_enable, 32'h10);
        csr_wr(2'd2, 32'h10);
        chk(irq_out == 1'b0 && irq_masked == 0, "R8 irq dropped on disable", irq_out, 0);
        chk(irq_raw[4] == 1'b1, "R7 raw kept on disable", irq_raw[4], 1);
        // R6: clear and new error in the same cycle.
        @(negedge clk);
        csr_we = 1'b1; csr_sel = 2'd0; csr_wdata = 32'h10;
        in_data = 32'h3333_3333; in_tag = 6'h33; in_derr = 1'b1; in_addr = 32'h7770;
        in_valid = 1'b1;
        @(negedge clk);
        csr_we = 1'b0; in_valid = 1'b0; in_derr = 1'b0;
        m_data.push_back(32'h3333_3333); m_tag.push_back(6'h33); m_err.push_back(1'b1);
        chk(irq_raw[4] == 1'b1, "R6 error beats clear", irq_raw[4], 1);
        chk(err_addr_log == 32'h7770, "R9 log reloads on clear", err_addr_log, 32'h7770);
        for (int i = 0; i < 3; i++) pop_check("irq");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_clean_burst();
        t_fill_adjacent();
        t_wrap();
        t_irq();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule